// File: doc/BRIEF.md
# Asymmetric Three-Slot Decode Steering

This block sits between an in-order fetch queue and a downstream micro-op queue. Each cycle the fetch queue presents a window of up to three instructions, oldest in lane 0. Each instruction carries a class code and a 3-bit micro-op count. The block decides how many of them enter decode this cycle. It places them into three decode slots that are not interchangeable. Slot 0 takes any legal instruction of one to four micro-ops. Slots 1 and 2 take only plain single-micro-op instructions. The fill is strictly in program order, so the first instruction that does not fit ends the group. That instruction waits to reach slot 0 in a later cycle. The best case is a 4-1-1 group, which carries six micro-ops.

The chosen group is registered into a one-entry packet stage. The packet holds three slot-valid bits and three micro-op counts, and it has a valid/ready handshake toward the downstream queue. The window side is consumed through a combinational take count, which the fetch queue uses to advance. An instruction whose count is zero or above four is never steered. When it is the oldest, it is consumed on its own and flagged. Two counters track the total micro-ops emitted and the cycles in which slot 1 or slot 2 stayed empty because of an ordering stall.

Top module: `dsteer_top`

## Requirements
- R1: While rst_n is low, out_valid, out_slot_vld, out_err, uop_total and stall_cycles are all zero.
- R2: A valid lane-0 instruction with a count from 1 to 4 of any class is placed in slot 0.
- R3: Class codes are 0 register op, 1 load-op, 2 store and 3 other. Lanes 1 and 2 may enter slots 1 and 2 only with a count of exactly 1 and class 0 or 3.
- R4: Slot k (k>0) is filled only if slot k-1 was filled this cycle and lane k is valid and eligible. The first ineligible lane ends the group, and in_take equals the number of lanes consumed.
- R5: A lane-0 count of 0 or above 4 consumes that lane alone (in_take=1) and gives a packet with out_err=1 and no slot valid. An illegal count in lane 1 or 2 only ends the group.
- R6: While out_valid=1 and out_ready=0, in_take is 0 and the packet (slot bits, counts, error) holds unchanged.
- R7: uop_total increases by the sum of the counts placed in slots, in the same cycle the packet is loaded.
- R8: stall_cycles increases by one for each loaded group that has slot 0 filled and that stops before slot 2 while the next lane is valid.
- R9: A group consumed at a clock edge appears on the outputs right after that edge. Unused slots show a count of zero, and out_valid is low after a cycle with nothing to consume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | NSLOT | Window lane valid bits, contiguous from lane 0 |
| in_cls | input | 2*NSLOT | Class code per lane, lane i at bits 2i+1:2i |
| in_uops | input | NSLOT*UOP_W | Micro-op count per lane, lane i at bits i*UOP_W+:UOP_W |
| in_take | output | TAKE_W | Number of window lanes consumed this cycle |
| out_valid | output | 1 | Packet present |
| out_ready | input | 1 | Downstream accepts packet |
| out_slot_vld | output | NSLOT | Slot valid bits |
| out_slot_uops | output | NSLOT*UOP_W | Micro-op count per slot |
| out_err | output | 1 | Packet carries a dropped illegal-count instruction |
| uop_total | output | CNT_W | Running micro-op total |
| stall_cycles | output | CNT_W | Cycles with a narrow slot lost to ordering |

## Verification
The assertions assume that the fetch queue presents valid lanes as a contiguous run starting at lane 0, so that no gap sits in front of an older instruction. Under that assumption they rely on the prefix shape of the slot bits and on the single-count rule for the narrow slots. Every vector, directed or random, builds in_vld as a run of ones from bit 0 and changes inputs only on the falling clock edge. The random part draws many single-count register ops mixed with load-ops, stores and illegal counts. This mix reaches every way a group can end.

// File: rtl/dsteer_pkg.sv
package dsteer_pkg;
  typedef enum logic [1:0] {
    CLS_REG   = 2'd0,
    CLS_LDOP  = 2'd1,
    CLS_STORE = 2'd2,
    CLS_OTHER = 2'd3
  } icls_e;

  // Narrow slots take only register-only or other single micro-op work
  function automatic logic narrow_ok(logic [1:0] cls, logic is_one);
    return is_one && (cls == CLS_REG || cls == CLS_OTHER);
  endfunction
endpackage

// File: rtl/dsteer_sel.sv
module dsteer_sel
  import dsteer_pkg::*;
#(
  parameter int NSLOT    = 3,
  parameter int UOP_W    = 3,
  parameter int MAX_UOPS = 4,
  parameter int TAKE_W   = 2
) (
  input  logic                   go,
  input  logic [NSLOT-1:0]       lane_vld,
  input  logic [2*NSLOT-1:0]     lane_cls,
  input  logic [NSLOT*UOP_W-1:0] lane_uops,
  output logic [NSLOT-1:0]       take_vec,
  output logic [TAKE_W-1:0]      take_cnt,
  output logic                   err0,
  output logic                   stall
);
  logic [NSLOT-1:0] legal;
  logic [NSLOT-1:0] narrow;
  logic [NSLOT-1:0] blk;

  for (genvar i = 0; i < NSLOT; i++) begin : g_cls
    logic [UOP_W-1:0] u;
    assign u         = lane_uops[i*UOP_W +: UOP_W];
    assign legal[i]  = (u != '0) && (u <= UOP_W'(MAX_UOPS));
    assign narrow[i] = narrow_ok(lane_cls[2*i +: 2], u == UOP_W'(1));
  end

  // Wide slot: oldest lane, any legal count
  assign take_vec[0] = go & lane_vld[0] & legal[0];
  assign err0        = go & lane_vld[0] & ~legal[0];
  assign blk[0]      = 1'b0;

  // Narrow slots: chained in program order
  for (genvar i = 1; i < NSLOT; i++) begin : g_chain
    assign take_vec[i] = take_vec[i-1] & lane_vld[i] & narrow[i];
    assign blk[i]      = take_vec[i-1] & lane_vld[i] & ~narrow[i];
  end

  assign stall = |blk;

  always_comb begin
    take_cnt = '0;
    for (int k = 0; k < NSLOT; k++) take_cnt = take_cnt + TAKE_W'(take_vec[k]);
    if (err0) take_cnt = TAKE_W'(1);
  end
endmodule

// File: rtl/dsteer_stage.sv
module dsteer_stage #(
  parameter int NSLOT = 3,
  parameter int UOP_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic [NSLOT-1:0]       take_vec,
  input  logic [NSLOT*UOP_W-1:0] lane_uops,
  input  logic                   err0,
  output logic                   full,
  output logic [NSLOT-1:0]       slot_vld,
  output logic [NSLOT*UOP_W-1:0] slot_uops,
  output logic                   err
);
  logic                   full_d;
  logic [NSLOT*UOP_W-1:0] uops_d;

  always_comb begin
    full_d = (|take_vec) | err0;
    for (int k = 0; k < NSLOT; k++)
      uops_d[k*UOP_W +: UOP_W] = take_vec[k] ? lane_uops[k*UOP_W +: UOP_W] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      slot_vld  <= '0;
      slot_uops <= '0;
      err       <= 1'b0;
    end else if (adv) begin
      full      <= full_d;
      slot_vld  <= take_vec;
      slot_uops <= uops_d;
      err       <= err0;
    end
  end
endmodule

// File: rtl/dsteer_stats.sv
module dsteer_stats #(
  parameter int NSLOT = 3,
  parameter int UOP_W = 3,
  parameter int CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       take_vec,
  input  logic [NSLOT*UOP_W-1:0] lane_uops,
  input  logic                   stall,
  output logic [CNT_W-1:0]       uop_total,
  output logic [CNT_W-1:0]       stall_cycles
);
  logic             en;
  logic [CNT_W-1:0] tot_d;
  logic [CNT_W-1:0] stl_d;

  assign en = |take_vec;

  always_comb begin
    tot_d = uop_total;
    for (int k = 0; k < NSLOT; k++)
      if (take_vec[k]) tot_d = tot_d + CNT_W'(lane_uops[k*UOP_W +: UOP_W]);
    stl_d = stall_cycles + CNT_W'(stall);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uop_total    <= '0;
      stall_cycles <= '0;
    end else if (en) begin
      uop_total    <= tot_d;
      stall_cycles <= stl_d;
    end
  end
endmodule

// File: rtl/dsteer_top.sv
module dsteer_top #(
  parameter int NSLOT    = 3,
  parameter int UOP_W    = 3,
  parameter int MAX_UOPS = 4,
  parameter int CNT_W    = 32,
  localparam int TAKE_W  = $clog2(NSLOT + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSLOT-1:0]       in_vld,
  input  logic [2*NSLOT-1:0]     in_cls,
  input  logic [NSLOT*UOP_W-1:0] in_uops,
  output logic [TAKE_W-1:0]      in_take,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [NSLOT-1:0]       out_slot_vld,
  output logic [NSLOT*UOP_W-1:0] out_slot_uops,
  output logic                   out_err,
  output logic [CNT_W-1:0]       uop_total,
  output logic [CNT_W-1:0]       stall_cycles
);
  logic             adv;
  logic [NSLOT-1:0] take_vec;
  logic             err0;
  logic             stall;

  assign adv = ~out_valid | out_ready;

  dsteer_sel #(.NSLOT(NSLOT), .UOP_W(UOP_W), .MAX_UOPS(MAX_UOPS), .TAKE_W(TAKE_W)) u_sel (
    .go(adv), .lane_vld(in_vld), .lane_cls(in_cls), .lane_uops(in_uops),
    .take_vec(take_vec), .take_cnt(in_take), .err0(err0), .stall(stall)
  );

  dsteer_stage #(.NSLOT(NSLOT), .UOP_W(UOP_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .adv(adv), .take_vec(take_vec), .lane_uops(in_uops),
    .err0(err0), .full(out_valid), .slot_vld(out_slot_vld), .slot_uops(out_slot_uops),
    .err(out_err)
  );

  dsteer_stats #(.NSLOT(NSLOT), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .take_vec(take_vec), .lane_uops(in_uops), .stall(stall),
    .uop_total(uop_total), .stall_cycles(stall_cycles)
  );
endmodule

// File: rtl/dsteer_chk.sv
module dsteer_chk #(
  parameter int NSLOT    = 3,
  parameter int UOP_W    = 3,
  parameter int MAX_UOPS = 4,
  parameter int CNT_W    = 32,
  parameter int TAKE_W   = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NSLOT-1:0]       in_vld,
  input logic [2*NSLOT-1:0]     in_cls,
  input logic [NSLOT*UOP_W-1:0] in_uops,
  input logic [TAKE_W-1:0]      in_take,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [NSLOT-1:0]       out_slot_vld,
  input logic [NSLOT*UOP_W-1:0] out_slot_uops,
  input logic                   out_err,
  input logic [CNT_W-1:0]       uop_total,
  input logic [CNT_W-1:0]       stall_cycles
);
  // Input contract: valid lanes form a run from lane 0
  a_r4_in_contig: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld & (in_vld + NSLOT'(1))) == '0);

  a_r4_take_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(in_take) <= $countones(in_vld));

  a_r4_slot_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (out_slot_vld & (out_slot_vld + NSLOT'(1))) == '0);

  a_r2_wide_legal: assert property (@(posedge clk) disable iff (!rst_n)
    out_slot_vld[0] |-> (out_slot_uops[UOP_W-1:0] != '0 &&
                         out_slot_uops[UOP_W-1:0] <= UOP_W'(MAX_UOPS)));

  a_r5_err_alone: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |-> out_valid && out_slot_vld == '0);

  a_r6_take_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> in_take == '0);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slot_vld) &&
                                $stable(out_slot_uops) && $stable(out_err));

  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (uop_total - $past(uop_total)) <= CNT_W'(NSLOT * MAX_UOPS));

  a_r8_step: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cycles - $past(stall_cycles)) <= CNT_W'(1));

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !out_slot_vld[s] |-> out_slot_uops[s*UOP_W +: UOP_W] == '0);
    if (s > 0) begin : g_narrow
      a_r3_narrow_one: assert property (@(posedge clk) disable iff (!rst_n)
        out_slot_vld[s] |-> out_slot_uops[s*UOP_W +: UOP_W] == UOP_W'(1));
    end
  end
endmodule

bind dsteer_top dsteer_chk #(
  .NSLOT(NSLOT), .UOP_W(UOP_W), .MAX_UOPS(MAX_UOPS), .CNT_W(CNT_W), .TAKE_W(TAKE_W)
) u_chk (.*);

// File: tb/dsteer_top_tb.sv
`timescale 1ns/1ps
module dsteer_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  in_vld;
  logic [5:0]  in_cls;
  logic [8:0]  in_uops;
  logic [1:0]  in_take;
  logic        out_valid;
  logic        out_ready;
  logic [2:0]  out_slot_vld;
  logic [8:0]  out_slot_uops;
  logic        out_err;
  logic [31:0] uop_total;
  logic [31:0] stall_cycles;

  int n_chk = 0, n_fail = 0, exp_tot = 0, exp_stl = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dsteer_top u_dut (.*);

  // {vld, cls lane2..0, uops lane2..0, take, err, stall}
  localparam logic [21:0] VEC [12] = '{
    {3'b111, 2'd3,2'd0,2'd1, 3'd1,3'd1,3'd4, 2'd3,1'b0,1'b0}, // R2 4-1-1
    {3'b111, 2'd0,2'd0,2'd0, 3'd1,3'd1,3'd1, 2'd3,1'b0,1'b0}, // R4 1-1-1
    {3'b111, 2'd0,2'd1,2'd0, 3'd1,3'd2,3'd1, 2'd1,1'b0,1'b1}, // R4 multi in lane1
    {3'b111, 2'd2,2'd0,2'd0, 3'd2,3'd1,3'd1, 2'd2,1'b0,1'b1}, // R4 store in lane2
    {3'b111, 2'd0,2'd1,2'd0, 3'd1,3'd1,3'd1, 2'd1,1'b0,1'b1}, // R3 load-op count 1
    {3'b111, 2'd0,2'd0,2'd0, 3'd1,3'd1,3'd5, 2'd1,1'b1,1'b0}, // R5 count 5
    {3'b001, 2'd0,2'd0,2'd0, 3'd1,3'd1,3'd0, 2'd1,1'b1,1'b0}, // R5 count 0
    {3'b111, 2'd0,2'd0,2'd0, 3'd1,3'd6,3'd1, 2'd1,1'b0,1'b1}, // R5 bad lane1
    {3'b001, 2'd0,2'd0,2'd3, 3'd0,3'd0,3'd3, 2'd1,1'b0,1'b0}, // R2 single lane
    {3'b011, 2'd0,2'd3,2'd2, 3'd0,3'd1,3'd2, 2'd2,1'b0,1'b0}, // R8 no stall
    {3'b000, 2'd0,2'd0,2'd0, 3'd0,3'd0,3'd0, 2'd0,1'b0,1'b0}, // R9 idle
    {3'b111, 2'd3,2'd3,2'd0, 3'd7,3'd1,3'd4, 2'd2,1'b0,1'b1}  // R3 bad lane2
  };

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference greedy grouping: returns {take, err, stall}
  function automatic logic [3:0] model(logic [2:0] v, logic [5:0] c, logic [8:0] u);
    int n = 0;
    logic st = 1'b0;
    if (!v[0]) return 4'b0;
    if (u[2:0] == 0 || u[2:0] > 4) return {2'd1, 1'b1, 1'b0};
    n = 1;
    for (int i = 1; i < 3; i++) begin
      if (n == i && v[i]) begin
        if (u[3*i +: 3] == 1 && (c[2*i +: 2] == 0 || c[2*i +: 2] == 3)) n++;
        else st = 1'b1;
      end
    end
    return {2'(n), 1'b0, st};
  endfunction

  function automatic logic [8:0] mask_uops(logic [1:0] t, logic e, logic [8:0] u);
    logic [8:0] r = '0;
    for (int i = 0; i < 3; i++) if (!e && i < t) r[3*i +: 3] = u[3*i +: 3];
    return r;
  endfunction

  function automatic int sum_uops(logic [8:0] m);
    return int'(m[2:0]) + int'(m[5:3]) + int'(m[8:6]);
  endfunction

  task automatic chk_pkt(string req, logic [1:0] t, logic e, logic [8:0] u);
    logic [2:0] sv = e ? 3'b000 : 3'((1 << t) - 1);
    chk(out_valid == ((t != 0) || e), req, "out_valid", out_valid, (t != 0) || e);
    chk(out_slot_vld == sv, req, "slot_vld", out_slot_vld, sv);
    chk(out_slot_uops == mask_uops(t, e, u), req, "slot_uops", out_slot_uops, mask_uops(t, e, u));
    chk(out_err == e, {req, " R5"}, "out_err", out_err, e);
  endtask

  task automatic chk_ctr(string tag);
    chk(uop_total == 32'(exp_tot), {"R7 ", tag}, "uop_total", uop_total, exp_tot);
    chk(stall_cycles == 32'(exp_stl), {"R8 ", tag}, "stall_cycles", stall_cycles, exp_stl);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] pt;
    logic       pe;
    logic [8:0] pu;
    rst_n = 1'b0; in_vld = '0; in_cls = '0; in_uops = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!out_valid && out_slot_vld == 0 && !out_err, "R1", "reset pkt", out_valid, 0);
    chk(uop_total == 0 && stall_cycles == 0, "R1", "reset ctr", uop_total, 0);
    rst_n = 1'b1;

    // Vector table
    foreach (VEC[k]) begin
      @(negedge clk);
      {in_vld, in_cls, in_uops} = VEC[k][21:4];
      #1;
      chk(in_take == VEC[k][3:2], "R2/R3/R4", $sformatf("take row %0d", k), in_take, VEC[k][3:2]);
      @(negedge clk);
      exp_tot += sum_uops(mask_uops(VEC[k][3:2], VEC[k][1], VEC[k][12:4]));
      exp_stl += int'(VEC[k][0]);
      chk_pkt("R9", VEC[k][3:2], VEC[k][1], VEC[k][12:4]);
      chk_ctr($sformatf("row %0d", k));
      in_vld = '0;
    end
    @(negedge clk);
    chk(!out_valid, "R9", "idle clears", out_valid, 0);

    // Backpressure: R6
    out_ready = 1'b0;
    {in_vld, in_cls, in_uops} = VEC[0][21:4];
    #1;
    chk(in_take == 2'd3, "R6", "take empty stage", in_take, 3);
    @(negedge clk);
    exp_tot += 6;
    {in_vld, in_cls, in_uops} = VEC[1][21:4];
    #1;
    chk(in_take == 2'd0, "R6", "take while held", in_take, 0);
    @(negedge clk);
    chk_pkt("R6", 2'd3, 1'b0, VEC[0][12:4]);
    chk_ctr("held");
    out_ready = 1'b1;
    #1;
    chk(in_take == 2'd3, "R6", "take after release", in_take, 3);
    @(negedge clk);
    exp_tot += 3;
    chk_pkt("R6", 2'd3, 1'b0, VEC[1][12:4]);
    chk_ctr("released");
    in_vld = '0;

    // Random streams against the greedy model
    pt = '0; pe = 1'b0; pu = '0;
    for (int it = 0; it < 400; it++) begin
      logic [3:0] m;
      logic [8:0] u;
      @(negedge clk);
      if (it > 0) chk_pkt("R4 rnd", pt, pe, pu);
      in_vld = 3'((1 << $urandom_range(0, 3)) - 1);
      in_cls = 6'($urandom);
      for (int i = 0; i < 3; i++)
        u[3*i +: 3] = ($urandom_range(0, 2) != 0) ? 3'd1 : 3'($urandom_range(0, 7));
      in_uops = u;
      m = model(in_vld, in_cls, in_uops);
      #1;
      chk(in_take == m[3:2], "R4 rnd", "take", in_take, m[3:2]);
      pt = m[3:2]; pe = m[1]; pu = in_uops;
      exp_tot += sum_uops(mask_uops(pt, pe, pu));
      exp_stl += int'(m[0]);
    end
    @(negedge clk);
    chk_pkt("R4 rnd", pt, pe, pu);
    chk_ctr("random");
    in_vld = '0;

    // Reset in mid-run: R1
    @(negedge clk);
    {in_vld, in_cls, in_uops} = VEC[0][21:4];
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!out_valid && out_slot_vld == 0, "R1", "async reset pkt", out_valid, 0);
    chk(uop_total == 0 && stall_cycles == 0, "R1", "async reset ctr", stall_cycles, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule